// File: doc/BRIEF.md
# Time-Multiplexed ISDN Frame Port

This block is a synchronous serial port that exchanges ISDN basic-access data between the line-side controller and local voice or data modules. Each 125 µs frame holds twelve byte slots on each of two open-drain lines. The downstream line carries data away from the controller and the upstream line carries data toward it. The port runs as the timing master. It derives a data clock at twice the bit rate, a bit clock at the bit rate and a one-bit frame sync from the system clock. It serializes a twelve-byte transmit image onto the downstream line and collects the upstream line into a twelve-byte receive image.

The slots form three four-byte channels. Channel 0 holds the two B bytes, the monitor byte and a control byte. Channel 1 holds two inter-chip bytes, a second monitor byte and its control byte. Channel 2 holds the bus-access bits. The port treats every slot as an opaque byte, with one exception: it decodes the command/indication code and the two handshake bits from the control byte of channel 0.

A single off input releases every pin at once. A test-only direction swap turns the two lines around in the slots selected by a mask. A strobe output marks the first B byte, the second B byte, or both, in channel 0 or channel 1.

The controller has three states:
- `S_OFF`: every pin released, counters held.
- `S_LOAD`: one cycle that captures the transmit image.
- `S_RUN`: framing active.

The transitions are:
- OFF→LOAD when `sw_off` is low.
- LOAD→RUN when `sw_off` is low.
- LOAD→OFF when `sw_off` is high.
- RUN→OFF when `sw_off` is high.

Top module: `tdm_frame_port`

## Requirements
- R1: While reset is held, `ck_oe`, `dd_pull`, `du_pull`, `frame_done` and `strobe_o` are 0 and every bit of `rx_frame` is 1.
- R2: A frame lasts BYTES×8×4×DIV system clocks (768 at the bench values). `fsc_o` is high for exactly the first bit period of each frame, which is 4×DIV clocks. `frame_done` is a one-clock pulse, once per frame.
- R3: While running, `dclk_o` rises twice per data bit and `bclk_o` rises once per data bit, giving 192 and 96 rising edges per frame.
- R4: Byte i of `tx_frame` sits at bits [8i+7:8i] and goes out in slot i, MSB first. The transmit image is captured at each frame start. On the driving line a 0 bit asserts the pull and a 1 bit releases it.
- R5: The upstream line is sampled at mid-bit, MSB first, into byte i of `rx_frame` (bits [8i+7:8i]). `rx_frame` changes only in the cycle in which `frame_done` is high.
- R6: `rx_ci0` = `rx_frame[29:26]`, `rx_mr0` = `rx_frame[25]` and `rx_mx0` = `rx_frame[24]`. Byte 3 is laid out MSB first as D[1:0], C/I[3:0], MR, MX.
- R7: The two pulls are never asserted together, and the port never pulls the line it is currently receiving on.
- R8: When `dir_swap` is 1, in every slot i with `swap_mask[i]` = 1, transmit data goes onto the upstream line and receive data comes from the downstream line. When `dir_swap` is 0, `swap_mask` has no effect.
- R9: One clock after `sw_off` is seen high, `ck_oe` and both pulls are 0 and no `frame_done` occurs. After `sw_off` returns low, the first `frame_done` appears BYTES×8×4×DIV+2 clocks later.
- R10: `strobe_o` is high during slot 4×`strobe_ch`+k for each k with `strobe_sel[k]` = 1, and low in every other slot and while off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_off | input | 1 | Release all pins and stop framing |
| dir_swap | input | 1 | Enable per-slot line reversal (test only) |
| swap_mask | input | BYTES | Slots reversed when `dir_swap` is set |
| strobe_ch | input | 1 | Strobe channel: 0 = B bytes, 1 = inter-chip bytes |
| strobe_sel | input | 2 | Strobe byte select: bit 0 = first byte, bit 1 = second byte |
| tx_frame | input | BYTES×8 | Transmit image, byte i at [8i+7:8i] |
| dd_in | input | 1 | Level sensed on the downstream line |
| du_in | input | 1 | Level sensed on the upstream line |
| dd_pull | output | 1 | Pull the downstream line low |
| du_pull | output | 1 | Pull the upstream line low |
| ck_oe | output | 1 | Output enable for the data clock, bit clock and frame sync |
| dclk_o | output | 1 | Data clock, two cycles per bit |
| bclk_o | output | 1 | Bit clock |
| fsc_o | output | 1 | Frame sync |
| strobe_o | output | 1 | Programmable data strobe |
| rx_frame | output | BYTES×8 | Receive image, byte i at [8i+7:8i] |
| frame_done | output | 1 | One-clock pulse when `rx_frame` is updated |
| rx_ci0 | output | 4 | Decoded C/I code from byte 3 |
| rx_mr0 | output | 1 | Decoded MR bit from byte 3 |
| rx_mx0 | output | 1 | Decoded MX bit from byte 3 |

## Verification
The bench builds the port with DIV=2 and BYTES=12. DIV=2 makes every quarter bit last two system clocks, which exercises the divider. It also separates the mid-bit sample point from the bit edges, so a sample taken one clock early or late shows up as a wrong byte. With BYTES=12, a frame is 768 clocks, so the full frame length, the wrap of the slot counter, the channel 1 strobe positions and the control byte decode can all be checked within a few frames per scenario.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_LOAD = 2'd1,
        S_RUN  = 2'd2
    } port_state_t;

    localparam int QTR_PER_BIT = 4;   // quarter ticks in one data bit
    localparam int BYTES_PER_CH = 4;  // slots per channel
    localparam int CTRL_SLOT = 3;     // control byte of channel 0
endpackage

// File: rtl/tdm_timebase.sv
`timescale 1ns/1ps
module tdm_timebase #(
    parameter int DIV   = 2,
    parameter int BYTES = 12,
    localparam int BW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic          tick,
    output logic [1:0]    qtr,
    output logic [2:0]    bitc,
    output logic [BW-1:0] bytec,
    output logic          frame_end
);
    localparam logic [BW-1:0] LAST_SLOT = BW'(BYTES - 1);

    generate
        if (DIV == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] DLAST = DW'(DIV - 1);
            logic [DW-1:0] dcnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             dcnt <= '0;
                else if (!run)          dcnt <= '0;
                else if (dcnt == DLAST) dcnt <= '0;
                else                    dcnt <= dcnt + 1'b1;
            end
            assign tick = run && (dcnt == DLAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qtr   <= '0;
            bitc  <= '0;
            bytec <= '0;
        end else if (!run) begin
            qtr   <= '0;
            bitc  <= '0;
            bytec <= '0;
        end else if (tick) begin
            qtr <= qtr + 1'b1;
            if (qtr == 2'd3) begin
                bitc <= bitc + 1'b1;
                if (bitc == 3'd7)
                    bytec <= (bytec == LAST_SLOT) ? '0 : bytec + 1'b1;
            end
        end
    end

    assign frame_end = tick && (qtr == 2'd3) && (bitc == 3'd7) && (bytec == LAST_SLOT);
endmodule

// File: rtl/tdm_tx_path.sv
`timescale 1ns/1ps
module tdm_tx_path #(
    parameter int BYTES = 12,
    localparam int BW   = $clog2(BYTES),
    localparam int FW   = BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] tx_frame,
    input  logic [2:0]    bitc,
    input  logic [BW-1:0] bytec,
    output logic          tx_bit
);
    logic [FW-1:0]   hold;
    logic [BW+2:0]   idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold <= '1;
        else if (load) hold <= tx_frame;
    end

    // slot*8 + (7 - bit): MSB leaves first
    assign idx    = {bytec, ~bitc};
    assign tx_bit = hold[idx];
endmodule

// File: rtl/tdm_rx_path.sv
`timescale 1ns/1ps
module tdm_rx_path #(
    parameter int BYTES = 12,
    localparam int BW   = $clog2(BYTES),
    localparam int FW   = BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic [2:0]    bitc,
    input  logic [BW-1:0] bytec,
    input  logic          commit,
    input  logic          rx_bit,
    output logic [FW-1:0] rx_frame,
    output logic          frame_done
);
    logic [6:0] sr;
    logic [7:0] shadow [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr <= '1;
        else if (sample) sr <= {sr[5:0], rx_bit};
    end

    generate
        for (genvar g = 0; g < BYTES; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    shadow[g] <= 8'hFF;
                else if (sample && bitc == 3'd7 && bytec == BW'(g))
                    shadow[g] <= {sr, rx_bit};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_frame   <= '1;
            frame_done <= 1'b0;
        end else begin
            frame_done <= commit;
            if (commit)
                for (int i = 0; i < BYTES; i++)
                    rx_frame[8*i +: 8] <= shadow[i];
        end
    end
endmodule

// File: rtl/tdm_frame_port.sv
`timescale 1ns/1ps
module tdm_frame_port
    import tdm_pkg::*;
#(
    parameter int DIV   = 2,
    parameter int BYTES = 12,
    localparam int BW   = $clog2(BYTES),
    localparam int FW   = BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_off,
    input  logic             dir_swap,
    input  logic [BYTES-1:0] swap_mask,
    input  logic             strobe_ch,
    input  logic [1:0]       strobe_sel,
    input  logic [FW-1:0]    tx_frame,
    input  logic             dd_in,
    input  logic             du_in,
    output logic             dd_pull,
    output logic             du_pull,
    output logic             ck_oe,
    output logic             dclk_o,
    output logic             bclk_o,
    output logic             fsc_o,
    output logic             strobe_o,
    output logic [FW-1:0]    rx_frame,
    output logic             frame_done,
    output logic [3:0]       rx_ci0,
    output logic             rx_mr0,
    output logic             rx_mx0
);
    port_state_t   state, nxt;
    logic          run, load_st;
    logic          tick, frame_end, tx_bit, rx_bit, swapped;
    logic [1:0]    qtr;
    logic [2:0]    bitc;
    logic [BW-1:0] bytec, sb0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:   if (!sw_off) nxt = S_LOAD;
            S_LOAD:  nxt = sw_off ? S_OFF : S_RUN;
            S_RUN:   if (sw_off) nxt = S_OFF;
            default: nxt = S_OFF;
        endcase
    end

    // per-state outputs
    always_comb begin
        run     = 1'b0;
        load_st = 1'b0;
        unique case (state)
            S_OFF:   ;
            S_LOAD:  load_st = 1'b1;
            S_RUN:   run = 1'b1;
            default: ;
        endcase
    end

    tdm_timebase #(.DIV(DIV), .BYTES(BYTES)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .qtr(qtr), .bitc(bitc), .bytec(bytec), .frame_end(frame_end)
    );

    tdm_tx_path #(.BYTES(BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(load_st || frame_end),
        .tx_frame(tx_frame), .bitc(bitc), .bytec(bytec), .tx_bit(tx_bit)
    );

    tdm_rx_path #(.BYTES(BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n), .sample(tick && qtr == 2'd1),
        .bitc(bitc), .bytec(bytec), .commit(frame_end && !sw_off),
        .rx_bit(rx_bit), .rx_frame(rx_frame), .frame_done(frame_done)
    );

    assign swapped = dir_swap && swap_mask[bytec];
    assign rx_bit  = swapped ? dd_in : du_in;
    assign dd_pull = run && !swapped && !tx_bit;
    assign du_pull = run &&  swapped && !tx_bit;

    assign ck_oe  = run;
    assign dclk_o = run && !qtr[0];
    assign bclk_o = run && !qtr[1];
    assign fsc_o  = run && (bitc == 3'd0) && (bytec == '0);

    assign sb0      = strobe_ch ? BW'(BYTES_PER_CH) : '0;
    assign strobe_o = run && ((strobe_sel[0] && bytec == sb0) ||
                              (strobe_sel[1] && bytec == sb0 + 1'b1));

    assign rx_ci0 = rx_frame[8*CTRL_SLOT+2 +: 4];
    assign rx_mr0 = rx_frame[8*CTRL_SLOT+1];
    assign rx_mx0 = rx_frame[8*CTRL_SLOT];
endmodule

// File: rtl/tdm_frame_port_chk.sv
`timescale 1ns/1ps
module tdm_frame_port_chk #(
    parameter int FW = 96
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_off,
    input logic          dir_swap,
    input logic          dd_pull,
    input logic          du_pull,
    input logic          ck_oe,
    input logic          strobe_o,
    input logic          frame_done,
    input logic [FW-1:0] rx_frame
);
    p_single_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_rx_atomic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame != $past(rx_frame)) |-> frame_done);

    p_one_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dd_pull && du_pull));

    p_swap_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_swap |-> !du_pull);

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off |=> (!ck_oe && !dd_pull && !du_pull && !frame_done));

    p_strobe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_oe |-> !strobe_o);
endmodule

bind tdm_frame_port tdm_frame_port_chk #(.FW(BYTES*8)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_off(sw_off), .dir_swap(dir_swap),
    .dd_pull(dd_pull), .du_pull(du_pull), .ck_oe(ck_oe),
    .strobe_o(strobe_o), .frame_done(frame_done), .rx_frame(rx_frame)
);

// File: tb/tb_tdm_frame_port.sv
`timescale 1ns/1ps
module tb_tdm_frame_port;
    localparam int DIV   = 2;
    localparam int BYTES = 12;
    localparam int FW    = BYTES * 8;
    localparam int QB    = 4 * DIV;
    localparam int FRAME = FW * QB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sw_off = 1'b0, dir_swap = 1'b0, strobe_ch = 1'b0;
    logic [BYTES-1:0] swap_mask = '0;
    logic [1:0] strobe_sel = 2'b00;
    logic [FW-1:0] tx_frame = '1;
    logic dd_in, du_in, dd_pull, du_pull, ck_oe, dclk_o, bclk_o, fsc_o, strobe_o;
    logic [FW-1:0] rx_frame;
    logic frame_done, rx_mr0, rx_mx0;
    logic [3:0] rx_ci0;

    logic ext_dd = 1'b0, ext_du = 1'b0;
    assign dd_in = !(dd_pull || ext_dd);
    assign du_in = !(du_pull || ext_du);

    tdm_frame_port #(.DIV(DIV), .BYTES(BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .sw_off(sw_off), .dir_swap(dir_swap),
        .swap_mask(swap_mask), .strobe_ch(strobe_ch), .strobe_sel(strobe_sel),
        .tx_frame(tx_frame), .dd_in(dd_in), .du_in(du_in),
        .dd_pull(dd_pull), .du_pull(du_pull), .ck_oe(ck_oe),
        .dclk_o(dclk_o), .bclk_o(bclk_o), .fsc_o(fsc_o), .strobe_o(strobe_o),
        .rx_frame(rx_frame), .frame_done(frame_done),
        .rx_ci0(rx_ci0), .rx_mr0(rx_mr0), .rx_mx0(rx_mx0)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit done_flag = 1'b0;

    // external device model and monitor state
    logic [FW-1:0] rx_pat = '1;
    logic [FW-1:0] tx_seen = '0;
    logic [BYTES-1:0] strobe_seen = '0;
    bit   bad_pull = 1'b0;
    int   cnt = 100000, since = 0, len_last = 0;
    int   dr = 0, br = 0, fh = 0, dr_last = 0, br_last = 0, fh_last = 0;
    logic fsc_prev = 1'b0, dclk_prev = 1'b0, bclk_prev = 1'b0;

    always @(negedge clk) begin
        int k, bi, bj;
        bit swp, pbit;
        if (fsc_o && !fsc_prev) cnt = 0;
        else                    cnt = cnt + 1;
        k = cnt / QB;
        if (ck_oe && k < FW) begin
            bi   = k / 8;
            bj   = k % 8;
            swp  = dir_swap && swap_mask[bi];
            pbit = rx_pat[bi*8 + 7 - bj];
            ext_dd = swp && !pbit;
            ext_du = !swp && !pbit;
            if (cnt % QB == QB / 2) begin
                tx_seen[bi*8 + 7 - bj] = swp ? !du_pull : !dd_pull;
                if (bj == 3) strobe_seen[bi] = strobe_o;
            end
            if (swp ? dd_pull : du_pull) bad_pull = 1'b1;
        end else begin
            ext_dd = 1'b0;
            ext_du = 1'b0;
        end
        if (dd_pull && du_pull) bad_pull = 1'b1;
        if (frame_done) begin
            len_last = since; dr_last = dr; br_last = br; fh_last = fh;
            since = 1;
            dr = (dclk_o && !dclk_prev) ? 1 : 0;
            br = (bclk_o && !bclk_prev) ? 1 : 0;
            fh = fsc_o ? 1 : 0;
        end else begin
            since++;
            if (dclk_o && !dclk_prev) dr++;
            if (bclk_o && !bclk_prev) br++;
            if (fsc_o) fh++;
        end
        fsc_prev = fsc_o; dclk_prev = dclk_o; bclk_prev = bclk_o;
    end

    task automatic chk(input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
        end
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!frame_done) @(negedge clk);
        #1;
    endtask

    function automatic logic [FW-1:0] mkpat(input logic [7:0] seed);
        logic [FW-1:0] p;
        for (int i = 0; i < BYTES; i++) p[8*i +: 8] = seed + 8'(i * 37);
        return p;
    endfunction

    task automatic run_frames(input string txreq, input logic [FW-1:0] txp,
                              input logic [FW-1:0] rxp, input logic dsw,
                              input logic [BYTES-1:0] msk, input logic sch,
                              input logic [1:0] ssel);
        logic [BYTES-1:0] sexp;
        int base;
        tx_frame = txp; rx_pat = rxp; dir_swap = dsw; swap_mask = msk;
        strobe_ch = sch; strobe_sel = ssel;
        wait_done();
        bad_pull = 1'b0;
        wait_done();
        chk("R5", "receive image", rx_frame, rxp);
        chk(txreq, "transmitted bytes", tx_seen, txp);
        chk("R6", "C/I code", FW'(rx_ci0), FW'(rxp[29:26]));
        chk("R6", "MR/MX", FW'({rx_mr0, rx_mx0}), FW'(rxp[25:24]));
        chk("R2", "frame length", FW'(len_last), FW'(FRAME));
        chk("R2", "sync high cycles", FW'(fh_last), FW'(QB));
        chk("R3", "data clock rises", FW'(dr_last), FW'(2 * FW));
        chk("R3", "bit clock rises", FW'(br_last), FW'(FW));
        chk("R7", "pull on receive line", FW'(bad_pull), '0);
        base = sch ? 4 : 0;
        sexp = '0;
        sexp[base]     = ssel[0];
        sexp[base + 1] = ssel[1];
        chk("R10", "strobe slots", FW'(strobe_seen), FW'(sexp));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "ck_oe in reset", FW'(ck_oe), '0);
        chk("R1", "pulls in reset", FW'({dd_pull, du_pull}), '0);
        chk("R1", "frame_done in reset", FW'(frame_done), '0);
        chk("R1", "strobe in reset", FW'(strobe_o), '0);
        chk("R1", "rx image in reset", rx_frame, '1);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        run_frames("R4", mkpat(8'h5A), mkpat(8'hC3), 1'b0, '0, 1'b0, 2'b11);
    endtask

    task automatic t_channel1();
        run_frames("R4", mkpat(8'h0F), mkpat(8'h96), 1'b0, '0, 1'b1, 2'b10);
    endtask

    task automatic t_swap();
        run_frames("R8", mkpat(8'h33), mkpat(8'hE1), 1'b1, 12'b0000_0000_1010, 1'b0, 2'b01);
    endtask

    task automatic t_swap_ignored();
        // R8: mask set but swap disabled, traffic must stay on normal lines
        run_frames("R8", mkpat(8'h71), mkpat(8'h2C), 1'b0, '1, 1'b0, 2'b00);
    endtask

    task automatic t_off();
        logic [FW-1:0] held;
        int n, dn, act;
        wait_done();
        held = rx_frame;
        sw_off = 1'b1;
        @(negedge clk);
        chk("R9", "ck_oe after off", FW'(ck_oe), '0);
        chk("R9", "pulls after off", FW'({dd_pull, du_pull}), '0);
        dn = 0; act = 0;
        repeat (FRAME + 20) begin
            @(negedge clk);
            if (frame_done) dn++;
            if (ck_oe || dd_pull || du_pull || strobe_o || fsc_o || dclk_o || bclk_o) act++;
        end
        chk("R9", "frame_done while off", FW'(dn), '0);
        chk("R9", "pin activity while off", FW'(act), '0);
        chk("R9", "rx image held while off", rx_frame, held);
        #1 sw_off = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!frame_done && n < 4 * FRAME);
        chk("R9", "restart to first frame_done", FW'(n), FW'(FRAME + 2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_channel1();
        t_swap();
        t_swap_ignored();
        t_off();
        t_basic();
        summary();
        $finish;
    end
endmodule